// File: doc/BRIEF.md
# Page Translation Cache

This block holds a small, fully associative set of recent logical-to-physical page translations. A requester presents a logical address with a read/write flag and a privilege flag. One cycle later the block answers with the physical address, the two-bit cache mode and any protection fault. If no stored translation matches, it instead raises a walk request with the logical page number. It then stays busy until an external table walker returns a descriptor on the fill port. That descriptor answers the pending access and, unless the cache is frozen, is installed into a slot picked round-robin.

A control register sets the mode of operation: whether translation is on, which page size to use, a half-capacity mode, a freeze (no-allocate) mode, and the cache mode and write protection that apply while translation is off. Two flush inputs drop cached translations: one keeps entries marked global, the other clears everything. A write that succeeds on a translation not yet marked modified sets the modified state in place and flags the response, so the walker can update the descriptor in memory.

Top module: `page_xlat_cache`

## Requirements
- R1: With the enable bit clear, an accepted lookup answers one cycle later with physical address equal to the logical address, cache mode equal to the default cache-mode field, a write-protect fault exactly when it is a write and the default write-protect bit is 1, no supervisor fault and no walk request.
- R2: After reset, translation is disabled, no entry is valid, busy, walk request and response valid are 0, and the replacement pointer is at slot 0.
- R3: The control register is written from `ctl_wdata` when `ctl_we` is 1, with this layout: bit 0 enable, bit 1 large page (0 = 4 kB, 1 = 8 kB), bit 2 half capacity, bit 3 freeze, bits 5:4 default cache mode, bit 6 default write protect.
- R4: With 4 kB pages the physical address is {page frame, logical[11:0]}. With 8 kB pages, bit 0 of the logical page number is left out of the match, and physical bit 12 is taken from logical bit 12.
- R5: A lookup that finds no match gives no response. One cycle later `walk_req` pulses for one cycle with `walk_vpn` = logical[31:12], and `busy` stays 1, with lookups ignored, until `fill_valid`. The cycle after the fill, the response for the pending access is valid and `busy` is 0.
- R6: A hit answers one cycle after the lookup with the stored frame and the stored cache mode. Cache modes pass through unchanged (00 write-through, 01 copyback, 10 inhibited precise, 11 inhibited imprecise).
- R7: A write through a write-protected translation reports `rsp_fault_wp`. A read through it reports no fault.
- R8: A user-mode access (`lk_super` = 0) through a supervisor-only translation reports `rsp_fault_sv`. A supervisor access does not.
- R9: A fault-free write through a translation not yet modified reports `rsp_mark_dirty` = 1 and marks the entry modified, so the next write to it reports 0. Reads and faulting writes report 0.
- R10: With freeze set, hits still work and fills still answer the pending access, but nothing is installed, so repeating the access misses again.
- R11: `flush` invalidates every entry whose global bit is 0. `flush_all` invalidates every entry and returns the replacement pointer to slot 0. Both act whether or not translation is enabled.
- R12: Slots are filled round-robin. With half capacity set, only slots below ENTRIES/2 are looked up and the pointer wraps within them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register value |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Logical address |
| lk_write | input | 1 | 1 = write access |
| lk_super | input | 1 | 1 = supervisor access |
| flush | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries, restart pointer |
| fill_valid | input | 1 | Walker result present |
| fill_ppn | input | ADDR_W-12 | Walker page frame |
| fill_wp | input | 1 | Walker write-protect bit |
| fill_super | input | 1 | Walker supervisor-only bit |
| fill_cmode | input | 2 | Walker cache mode |
| fill_global | input | 1 | Walker global bit |
| fill_mod | input | 1 | Walker modified bit |
| busy | output | 1 | Miss outstanding; lookups ignored |
| walk_req | output | 1 | One-cycle table walk request |
| walk_vpn | output | ADDR_W-12 | Page number to walk |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_cmode | output | 2 | Cache mode |
| rsp_fault_wp | output | 1 | Write-protect fault |
| rsp_fault_sv | output | 1 | Supervisor fault |
| rsp_mark_dirty | output | 1 | Write set the modified state |

## Verification
The bench uses an eight-slot instance. It goes after the round-robin victim, which a wrong pointer would show as the wrong translation surviving an overflow. It checks that half capacity hides upper slots and wraps at four; a design that only narrowed the pointer would still hit in slot five. It checks the 8 kB case, where a mask on the wrong bit would miss on the odd page or pass the frame's low bit through. It covers the freeze mode, where allocating anyway would turn the repeat access into a hit. It checks that global entries survive a plain flush, and that the modified flag fires exactly once per clean translation, including the write served straight from a fill.

// File: rtl/xlc_pkg.sv
// Shared types for the page translation cache.
package xlc_pkg;

    // Control register; enable sits in bit 0, default write protect in bit 6.
    typedef struct packed {
        logic       dflt_wp;
        logic [1:0] dflt_cm;
        logic       freeze;
        logic       half_cap;
        logic       big_page;
        logic       enable;
    } xlc_ctl_t;

    localparam int CTL_W    = 7;
    localparam int PG_SHIFT = 12;

    // Per-translation attribute bits held beside each frame number.
    typedef struct packed {
        logic       wp;
        logic       sv;
        logic [1:0] cm;
        logic       glob;
    } xlc_attr_t;

endpackage

// File: rtl/xlc_ctl_reg.sv
// Control register of the translation cache.
// Assumes: writes take effect on the next cycle; reset clears every field,
// so translation starts disabled.
module xlc_ctl_reg
    import xlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output xlc_ctl_t         ctl
);

    // Hold the control word; load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl <= xlc_ctl_t'(wdata);
        end
    end

endmodule

// File: rtl/xlc_repl_ptr.sv
// Round-robin victim pointer for the translation cache.
// Assumes: ENTRIES is a power of two of at least 4; in half-capacity mode
// the slot handed out always lies in the lower half, and the pointer wraps
// there. A restart puts it back to slot 0.
module xlc_repl_ptr #(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int HALF    = ENTRIES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half,
    input  logic             advance,
    input  logic             restart,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] wrap_at;

    // Last slot before wrapping in the current capacity mode.
    always_comb begin
        wrap_at = half ? IDX_W'(HALF - 1) : IDX_W'(ENTRIES - 1);
        slot    = half ? {1'b0, ptr_q[IDX_W-2:0]} : ptr_q;
    end

    // Step the pointer after each allocation, wrapping at the mode limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (ptr_q >= wrap_at) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    a_r12_half_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && half && ptr_q == IDX_W'(HALF - 1)) |=> ptr_q == '0)
        else $error("R12 pointer did not wrap at half capacity");

    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ptr_q == '0)
        else $error("R11 flush_all did not restart pointer");

endmodule

// File: rtl/xlc_tag_array.sv
// Fully associative translation store with parallel match.
// Assumes: at most one entry matches in a given mode (fills only follow
// misses); when several do, the lowest index wins. Only the valid bits are
// reset. Frame, tag and attributes are don't-care until written.
module xlc_tag_array
    import xlc_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int TAG_W   = 20,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int HALF    = ENTRIES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    // match port
    input  logic [TAG_W-1:0] q_tag,
    input  logic             q_big,
    input  logic             q_half,
    output logic             q_hit,
    output logic [IDX_W-1:0] q_idx,
    output logic [TAG_W-1:0] q_ppn,
    output xlc_attr_t        q_attr,
    output logic             q_mod,
    // install port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TAG_W-1:0] wr_ppn,
    input  xlc_attr_t        wr_attr,
    input  logic             wr_mod,
    // modified-state update
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx,
    // invalidation
    input  logic             flush_loc,
    input  logic             flush_all
);

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] mod_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] glob_vec;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [TAG_W-1:0]   ppn_q  [ENTRIES];
    xlc_attr_t          attr_q [ENTRIES];
    logic [TAG_W-1:0]   cmp_mask;

    // Large pages ignore the lowest page-number bit in the compare.
    assign cmp_mask = q_big ? {{(TAG_W-1){1'b1}}, 1'b0} : {TAG_W{1'b1}};

    // One comparator per slot; upper slots are gated off in half mode.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        localparam bit LOW = (gi < HALF);
        logic in_use;
        assign in_use      = LOW ? 1'b1 : !q_half;
        assign match[gi]   = vld_q[gi] && in_use
                             && (((tag_q[gi] ^ q_tag) & cmp_mask) == '0);
        assign glob_vec[gi] = attr_q[gi].glob;
    end

    // Pick the lowest matching slot and read out its contents.
    always_comb begin
        q_hit = |match;
        q_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                q_idx = IDX_W'(i);
            end
        end
        q_ppn  = ppn_q[q_idx];
        q_attr = attr_q[q_idx];
        q_mod  = mod_q[q_idx];
    end

    // Valid bits: flushes first, an install in the same cycle wins its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (flush_all) begin
                vld_q <= '0;
            end else if (flush_loc) begin
                vld_q <= vld_q & glob_vec;
            end
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end
    end

    // Slot payload: written on install only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            ppn_q[wr_idx]  <= wr_ppn;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    // Modified state: set by install, or in place by a clean write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (wr_en) begin
            mod_q[wr_idx] <= wr_mod;
        end else if (mark_en) begin
            mod_q[mark_idx] <= 1'b1;
        end
    end

    a_r11_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !wr_en) |=> vld_q == '0)
        else $error("R11 entries survived flush_all");

    a_r11_globals_only: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_loc && !flush_all && !wr_en) |=> (vld_q & ~glob_vec) == '0)
        else $error("R11 non-global entry survived flush");

    a_r12_half_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (q_half && q_hit) |-> q_idx < IDX_W'(HALF))
        else $error("R12 hit outside lower half");

    a_r9_mark_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> vld_q[mark_idx])
        else $error("R9 modified update on an invalid slot");

endmodule

// File: rtl/page_xlat_cache.sv
// Page translation cache top level.
// Takes one lookup per cycle while not busy and answers in the next cycle.
// On a miss it requests a table walk, holds busy, and answers the pending
// access from the fill data. The fill is installed unless frozen.
// Assumes: the walker answers only while busy; fill and lookup never need
// to be served in the same cycle (lookups are ignored while busy).
module page_xlat_cache
    import xlc_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int ENTRIES = 64,
    localparam int TAG_W   = ADDR_W - PG_SHIFT,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_write,
    input  logic              lk_super,
    input  logic              flush,
    input  logic              flush_all,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_ppn,
    input  logic              fill_wp,
    input  logic              fill_super,
    input  logic [1:0]        fill_cmode,
    input  logic              fill_global,
    input  logic              fill_mod,
    output logic              busy,
    output logic              walk_req,
    output logic [TAG_W-1:0]  walk_vpn,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_cmode,
    output logic              rsp_fault_wp,
    output logic              rsp_fault_sv,
    output logic              rsp_mark_dirty
);

    xlc_ctl_t          ctl;
    logic              busy_q;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_wr;
    logic              pend_sv;

    logic              acc;
    logic              fill_take;
    logic              q_hit;
    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_ppn;
    xlc_attr_t         q_attr;
    logic              q_mod;
    logic [IDX_W-1:0]  victim;

    logic [TAG_W-1:0]  s_ppn;
    xlc_attr_t         s_attr;
    logic              s_mod;
    logic [ADDR_W-1:0] s_addr;
    logic              s_wr;
    logic              s_sv;
    logic              s_fault_wp;
    logic              s_fault_sv;
    logic              s_dirty;
    logic [ADDR_W-1:0] s_paddr;
    xlc_attr_t         fill_attr;
    logic              wr_en;
    logic              mark_en;

    xlc_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    // Requests accepted only while idle; fills accepted only while busy.
    assign acc       = lk_valid && !busy_q;
    assign fill_take = fill_valid && busy_q;
    assign fill_attr = '{wp: fill_wp, sv: fill_super, cm: fill_cmode,
                         glob: fill_global};

    // Choose the translation source (fill or hit) and derive the result.
    always_comb begin
        if (fill_take) begin
            s_ppn  = fill_ppn;
            s_attr = fill_attr;
            s_mod  = fill_mod;
            s_addr = pend_addr;
            s_wr   = pend_wr;
            s_sv   = pend_sv;
        end else begin
            s_ppn  = q_ppn;
            s_attr = q_attr;
            s_mod  = q_mod;
            s_addr = lk_addr;
            s_wr   = lk_write;
            s_sv   = lk_super;
        end
        s_fault_sv = s_attr.sv && !s_sv;
        s_fault_wp = s_wr && s_attr.wp;
        s_dirty    = s_wr && !s_fault_wp && !s_fault_sv && !s_mod;
        s_paddr    = {s_ppn[TAG_W-1:1],
                      ctl.big_page ? s_addr[PG_SHIFT] : s_ppn[0],
                      s_addr[PG_SHIFT-1:0]};
    end

    assign wr_en   = fill_take && !ctl.freeze;
    assign mark_en = acc && ctl.enable && q_hit && s_dirty;

    xlc_tag_array #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_tag     (lk_addr[ADDR_W-1:PG_SHIFT]),
        .q_big     (ctl.big_page),
        .q_half    (ctl.half_cap),
        .q_hit     (q_hit),
        .q_idx     (q_idx),
        .q_ppn     (q_ppn),
        .q_attr    (q_attr),
        .q_mod     (q_mod),
        .wr_en     (wr_en),
        .wr_idx    (victim),
        .wr_tag    (pend_addr[ADDR_W-1:PG_SHIFT]),
        .wr_ppn    (fill_ppn),
        .wr_attr   (fill_attr),
        .wr_mod    (fill_mod | s_dirty),
        .mark_en   (mark_en),
        .mark_idx  (q_idx),
        .flush_loc (flush),
        .flush_all (flush_all)
    );

    xlc_repl_ptr #(
        .ENTRIES (ENTRIES)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .half    (ctl.half_cap),
        .advance (wr_en),
        .restart (flush_all),
        .slot    (victim)
    );

    // Response, walk request and miss bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q         <= 1'b0;
            walk_req       <= 1'b0;
            walk_vpn       <= '0;
            pend_addr      <= '0;
            pend_wr        <= 1'b0;
            pend_sv        <= 1'b0;
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_cmode      <= '0;
            rsp_fault_wp   <= 1'b0;
            rsp_fault_sv   <= 1'b0;
            rsp_mark_dirty <= 1'b0;
        end else begin
            rsp_valid      <= 1'b0;
            walk_req       <= 1'b0;
            rsp_mark_dirty <= 1'b0;
            if (fill_take || (acc && ctl.enable && q_hit)) begin
                rsp_valid      <= 1'b1;
                rsp_paddr      <= s_paddr;
                rsp_cmode      <= s_attr.cm;
                rsp_fault_wp   <= s_fault_wp;
                rsp_fault_sv   <= s_fault_sv;
                rsp_mark_dirty <= s_dirty;
                if (fill_take) begin
                    busy_q <= 1'b0;
                end
            end else if (acc && !ctl.enable) begin
                rsp_valid    <= 1'b1;
                rsp_paddr    <= lk_addr;
                rsp_cmode    <= ctl.dflt_cm;
                rsp_fault_wp <= lk_write && ctl.dflt_wp;
                rsp_fault_sv <= 1'b0;
            end else if (acc) begin
                busy_q    <= 1'b1;
                walk_req  <= 1'b1;
                walk_vpn  <= lk_addr[ADDR_W-1:PG_SHIFT];
                pend_addr <= lk_addr;
                pend_wr   <= lk_write;
                pend_sv   <= lk_super;
            end
        end
    end

    assign busy = busy_q;

    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ctl.enable) |=> rsp_valid && rsp_paddr == $past(lk_addr)
                                 && !rsp_fault_sv && !walk_req)
        else $error("R1 disabled lookup not passed through");

    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fill_valid) |=> busy_q)
        else $error("R5 busy dropped without fill");

    a_r5_walk_pending: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> busy_q && !rsp_valid)
        else $error("R5 walk request without busy or with response");

    a_r5_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && busy_q) |=> rsp_valid && !busy_q)
        else $error("R5 fill did not produce a response");

    a_r9_dirty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mark_dirty |-> rsp_valid && !rsp_fault_wp && !rsp_fault_sv)
        else $error("R9 modified flag on a faulting or absent response");

endmodule

// File: tb/page_xlat_cache_tb.sv
`timescale 1ns/1ps
module page_xlat_cache_tb;

    localparam int AW = 32;
    localparam int TW = AW - 12;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [6:0]    ctl_wdata = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_write = 1'b0;
    logic          lk_super = 1'b0;
    logic          flush = 1'b0;
    logic          flush_all = 1'b0;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_ppn = '0;
    logic          fill_wp = 1'b0;
    logic          fill_super = 1'b0;
    logic [1:0]    fill_cmode = '0;
    logic          fill_global = 1'b0;
    logic          fill_mod = 1'b0;
    logic          busy, walk_req, rsp_valid;
    logic [TW-1:0] walk_vpn;
    logic [AW-1:0] rsp_paddr;
    logic [1:0]    rsp_cmode;
    logic          rsp_fault_wp, rsp_fault_sv, rsp_mark_dirty;

    int total = 0;
    int bad = 0;

    page_xlat_cache #(.ADDR_W(AW), .ENTRIES(NE)) u_dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic [6:0] v);
        ctl_wdata = v;
        ctl_we = 1'b1;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic pulse_flush(input bit all);
        if (all) flush_all = 1'b1; else flush = 1'b1;
        tick();
        flush_all = 1'b0;
        flush = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input bit wr, input bit sv);
        lk_addr = a;
        lk_write = wr;
        lk_super = sv;
        lk_valid = 1'b1;
        tick();
        lk_valid = 1'b0;
    endtask

    function automatic logic [TW-1:0] ppn_of(input logic [TW-1:0] v);
        return v ^ 20'h5A5A4;
    endfunction

    // Lookup; on a miss check the walk request and answer it.
    task automatic xlate(input logic [AW-1:0] a, input bit wr, input bit sv,
                         input bit fwp, input bit fsv, input logic [1:0] fcm,
                         input bit fglob, input bit fmod, output bit missed);
        lookup(a, wr, sv);
        missed = walk_req;
        if (missed) begin
            chk(walk_vpn == a[31:12] && busy && !rsp_valid, "R5 walk_vpn",
                32'(walk_vpn), 32'(a[31:12]));
            tick();
            chk(busy, "R5 busy held", 32'(busy), 32'd1);
            fill_ppn = ppn_of(a[31:12]);
            fill_wp = fwp;
            fill_super = fsv;
            fill_cmode = fcm;
            fill_global = fglob;
            fill_mod = fmod;
            fill_valid = 1'b1;
            tick();
            fill_valid = 1'b0;
            chk(rsp_valid && !busy, "R5 fill response", 32'(rsp_valid), 32'd1);
        end
    endtask

    function automatic logic [AW-1:0] exp4k(input logic [AW-1:0] a);
        return {ppn_of(a[31:12]), a[11:0]};
    endfunction

    initial begin
        #(8ns * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit m;
        logic [AW-1:0] a;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2: reset state
        chk(!busy && !walk_req && !rsp_valid, "R2 idle after reset",
            {busy, walk_req, rsp_valid}, 0);
        lookup(32'hDEAD_B123, 1'b0, 1'b0);
        chk(rsp_valid && rsp_paddr == 32'hDEAD_B123 && !walk_req,
            "R2 translation off after reset", rsp_paddr, 32'hDEAD_B123);

        // R1/R3: disabled pass-through under every default setting
        for (int i = 0; i < 16; i++) begin
            logic [3:0] b;
            b = 4'(i);
            set_ctl({b[2], b[1:0], 4'b0000});
            a = 32'h1357_9BDF * (i + 1);
            lookup(a, b[0], b[3]);
            chk(rsp_valid && rsp_paddr == a, "R1 identity address", rsp_paddr, a);
            chk(rsp_cmode == b[1:0], "R3 default cache mode",
                32'(rsp_cmode), 32'(b[1:0]));
            chk(rsp_fault_wp == (b[0] & b[2]) && !rsp_fault_sv && !walk_req,
                "R1 default write protect", 32'(rsp_fault_wp), 32'(b[0] & b[2]));
        end

        // R5/R6/R12: fill all slots with 4 kB pages, then overflow
        set_ctl(7'h01);
        for (int k = 0; k < NE; k++) begin
            a = {20'(32'h100 + k), 12'(k * 291)};
            xlate(a, 1'b0, 1'b0, 1'b0, 1'b0, 2'(k), 1'b0, 1'b0, m);
            chk(m, "R5 cold miss", 32'(m), 1);
            chk(rsp_paddr == exp4k(a) && rsp_cmode == 2'(k), "R4 4k fill address",
                rsp_paddr, exp4k(a));
        end
        for (int k = 0; k < NE; k++) begin
            a = {20'(32'h100 + k), 12'(k * 77 + 5)};
            lookup(a, 1'b0, 1'b1);
            chk(rsp_valid && !walk_req && rsp_paddr == exp4k(a), "R6 hit address",
                rsp_paddr, exp4k(a));
            chk(rsp_cmode == 2'(k), "R6 cache mode passthrough",
                32'(rsp_cmode), 32'(k));
        end
        xlate({20'h108, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        xlate({20'h100, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(m, "R12 slot 0 evicted first", 32'(m), 1);
        xlate({20'h103, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!m, "R12 slot 3 kept", 32'(m), 0);

        // R7/R8: protection
        pulse_flush(1'b1);
        xlate({20'h200, 12'h040}, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, m);
        chk(!rsp_fault_wp && !rsp_fault_sv, "R7 read of protected page",
            32'(rsp_fault_wp), 0);
        lookup({20'h200, 12'h044}, 1'b1, 1'b1);
        chk(rsp_valid && rsp_fault_wp && !rsp_mark_dirty, "R7 write fault",
            32'(rsp_fault_wp), 1);
        xlate({20'h201, 12'h0}, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, m);
        chk(!rsp_fault_sv, "R8 supervisor allowed", 32'(rsp_fault_sv), 0);
        lookup({20'h201, 12'h8}, 1'b0, 1'b0);
        chk(rsp_valid && rsp_fault_sv, "R8 user fault", 32'(rsp_fault_sv), 1);

        // R9: modified state
        xlate({20'h300, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!rsp_mark_dirty, "R9 read leaves clean", 32'(rsp_mark_dirty), 0);
        lookup({20'h300, 12'h10}, 1'b1, 1'b0);
        chk(rsp_valid && rsp_mark_dirty, "R9 first write marks", 32'(rsp_mark_dirty), 1);
        lookup({20'h300, 12'h14}, 1'b1, 1'b0);
        chk(rsp_valid && !rsp_mark_dirty, "R9 second write quiet",
            32'(rsp_mark_dirty), 0);
        xlate({20'h301, 12'h0}, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(m && rsp_mark_dirty, "R9 write via fill marks", 32'(rsp_mark_dirty), 1);
        lookup({20'h301, 12'h4}, 1'b1, 1'b0);
        chk(rsp_valid && !rsp_mark_dirty, "R9 installed as modified",
            32'(rsp_mark_dirty), 0);

        // R10: freeze
        set_ctl(7'h09);
        xlate({20'h400, 12'h123}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, m);
        chk(m && rsp_paddr == exp4k({20'h400, 12'h123}) && rsp_cmode == 2'd3,
            "R10 frozen fill answers", rsp_paddr, exp4k({20'h400, 12'h123}));
        lookup({20'h400, 12'h123}, 1'b0, 1'b0);
        chk(walk_req && !rsp_valid, "R10 not allocated", 32'(walk_req), 1);
        fill_valid = 1'b1;
        tick();
        fill_valid = 1'b0;
        lookup({20'h300, 12'h0}, 1'b0, 1'b0);
        chk(rsp_valid && !walk_req, "R10 frozen hit", 32'(rsp_valid), 1);

        // R11: flushes
        set_ctl(7'h01);
        pulse_flush(1'b1);
        xlate({20'h500, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, m);
        xlate({20'h501, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        pulse_flush(1'b0);
        xlate({20'h500, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, m);
        chk(!m, "R11 global survives flush", 32'(m), 0);
        xlate({20'h501, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(m, "R11 local flushed", 32'(m), 1);
        set_ctl(7'h00);
        pulse_flush(1'b1);
        set_ctl(7'h01);
        xlate({20'h500, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, m);
        chk(m, "R11 flush_all while disabled", 32'(m), 1);

        // R12: half capacity hides upper slots
        pulse_flush(1'b1);
        for (int k = 0; k < NE; k++)
            xlate({20'(32'h800 + k), 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        set_ctl(7'h05);
        xlate({20'h801, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!m, "R12 lower slot visible", 32'(m), 0);
        xlate({20'h805, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(m, "R12 upper slot hidden", 32'(m), 1);
        // R12: wrap at half
        pulse_flush(1'b1);
        for (int k = 0; k < 5; k++)
            xlate({20'(32'h600 + k), 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        xlate({20'h604, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!m, "R12 newest kept", 32'(m), 0);
        xlate({20'h601, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!m, "R12 slot 1 kept", 32'(m), 0);
        xlate({20'h600, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(m, "R12 wrapped into slot 0", 32'(m), 1);
        // contrast: full capacity keeps all five
        set_ctl(7'h01);
        pulse_flush(1'b1);
        for (int k = 0; k < 5; k++)
            xlate({20'(32'h680 + k), 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        xlate({20'h680, 12'h0}, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(!m, "R12 full mode keeps slot 0", 32'(m), 0);

        // R4: 8 kB pages
        pulse_flush(1'b1);
        set_ctl(7'h03);
        a = {20'h700, 12'hABC};
        xlate(a, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, m);
        chk(rsp_paddr == {ppn_of(20'h700), 12'hABC}, "R4 8k even page",
            rsp_paddr, {ppn_of(20'h700), 12'hABC});
        a = {20'h701, 12'h123};
        lookup(a, 1'b0, 1'b0);
        chk(rsp_valid && !walk_req, "R4 8k odd half hits", 32'(rsp_valid), 1);
        chk(rsp_paddr == {ppn_of(20'h700) | 20'h1, 12'h123}, "R4 8k bit 12 from address",
            rsp_paddr, {ppn_of(20'h700) | 20'h1, 12'h123});
        set_ctl(7'h01);
        lookup(a, 1'b0, 1'b0);
        chk(walk_req && !rsp_valid, "R4 4k odd page misses", 32'(walk_req), 1);
        fill_valid = 1'b1;
        tick();
        fill_valid = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule